// File: doc/BRIEF.md
# Victim Line Buffer

This block sits beside a direct-mapped cache and gives lines that the cache throws out a second chance. It holds a few whole cache lines (four by default) with their line addresses. Any line can sit in any slot. When the primary cache misses, it presents the missing line address together with the line it is about to overwrite. The address is compared against every slot in the same cycle.

If a slot matches, the buffered line goes back to the primary cache and the line being overwritten takes over that slot, so the two lines trade places in one operation. The next level is then not asked for anything. If no slot matches, the block asks the next level for the line. It also keeps the line being overwritten, placing it in a free slot when there is one and otherwise in the slot used least recently. Fill data from the next level goes straight to the primary cache and does not pass through this block. Write handling belongs to the primary cache.

Top module: `victim_cache`

## Requirements
- R1: While reset is held and after it is released, every slot is empty, and `resp_valid_o`, `resp_hit_o`, `nl_req_o` and `resp_data_o` are 0.
- R2: A request whose line address matches a valid slot produces, on the cycle after the request, `resp_valid_o`=1, `resp_hit_o`=1 and `resp_data_o` equal to the data stored in that slot. `nl_req_o` stays 0 on that cycle.
- R3: A request that matches no valid slot produces, on the cycle after the request, `resp_valid_o`=1, `resp_hit_o`=0, `resp_data_o`=0, `nl_req_o`=1 and `nl_addr_o` equal to the requested line address.
- R4: On a hit with `evict_valid_i`=1, the matched slot takes the evicted address and data in the same edge. A later request for the returned address then misses, and a later request for the evicted address hits.
- R5: On a miss with `evict_valid_i`=1, the evicted line is stored in a slot. An empty slot is used if one exists, so up to the slot count of distinct evicted lines are all retained.
- R6: On a miss with `evict_valid_i`=1 and no empty slot, the slot whose line was least recently stored or swapped is overwritten. Every insert or hit makes its slot the most recent.
- R7: A hit with `evict_valid_i`=0 empties the matched slot. A miss with `evict_valid_i`=0 stores nothing and leaves every held line in place.
- R8: A cycle without `req_valid_i` produces `resp_valid_o`=0 and `nl_req_o`=0 on the next cycle and changes no slot. The evict inputs are ignored on such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Primary cache miss: lookup request |
| req_addr_i | input | ADDR_W | Line address being looked up |
| evict_valid_i | input | 1 | The primary cache displaces a valid line with this request |
| evict_addr_i | input | ADDR_W | Line address of the displaced line |
| evict_data_i | input | LINE_W | Data of the displaced line |
| resp_valid_o | output | 1 | Lookup result present (one cycle after request) |
| resp_hit_o | output | 1 | Lookup found the line |
| resp_data_o | output | LINE_W | Returned line data on a hit, 0 otherwise |
| nl_req_o | output | 1 | Fetch request to the next level |
| nl_addr_o | output | ADDR_W | Line address to fetch from the next level |

## Verification
Every result of this block is registered once. The hit or miss flag, the returned data and the next-level fetch are all due on the first rising edge after the request is sampled. Slot contents change on that same edge, so their effect shows up in the response to the next request. The bench drives a request on a falling edge and compares all outputs on the following falling edge, half a cycle after they settle, against a queue-based model that was advanced when the request was driven. Replacement order and swaps show up only through later hits and misses. For that reason the directed sequences revisit lines after each fill, swap and eviction.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    VC_OP_NONE,
    VC_OP_SWAP,
    VC_OP_FILL
  } vc_op_e;
endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int N  = 4,
  parameter int AW = 26,
  parameter int IW = 2
) (
  input  logic [N-1:0]         valid_i,
  input  logic [N-1:0][AW-1:0] tag_i,
  input  logic [AW-1:0]        addr_i,
  output logic [N-1:0]         hit_vec_o,
  output logic                 hit_o,
  output logic [IW-1:0]        hit_idx_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (tag_i[g] == addr_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec_o[i]) hit_idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          touch_i,
  input  logic [IW-1:0] touch_idx_i,
  input  logic [N-1:0]  valid_i,
  output logic [IW-1:0] victim_idx_o
);
  localparam logic [IW-1:0] AGE_MAX = IW'(N - 1);

  logic [N-1:0][IW-1:0] age_q;
  logic [N-1:0]         oldest_vec;

  // ages form a permutation of 0..N-1; 0 = most recent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx_i)             age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest_vec[g] = (age_q[g] == AGE_MAX);
  end

  // lowest empty slot first, otherwise the oldest
  always_comb begin
    victim_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (oldest_vec[i]) victim_idx_o = IW'(i);
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) victim_idx_o = IW'(i);
    end
  end

  // R6
  lru_single_oldest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(oldest_vec) == 1);

  // R6
  lru_touch_newest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> age_q[$past(touch_idx_i)] == '0);
endmodule

// File: rtl/vc_entry_array.sv
module vc_entry_array #(
  parameter int N  = 4,
  parameter int AW = 26,
  parameter int DW = 64,
  parameter int IW = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IW-1:0]        wr_idx_i,
  input  logic                 wr_valid_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [DW-1:0]        wr_data_i,
  output logic [N-1:0]         valid_o,
  output logic [N-1:0][AW-1:0] tag_o,
  output logic [N-1:0][DW-1:0] data_o
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        tag_o[g]   <= '0;
        data_o[g]  <= '0;
      end else if (sel) begin
        valid_o[g] <= wr_valid_i;
        tag_o[g]   <= wr_addr_i;
        data_o[g]  <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/victim_cache.sv
module victim_cache #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int LINE_W  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              evict_valid_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  input  logic [LINE_W-1:0] evict_data_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [LINE_W-1:0] resp_data_o,
  output logic              nl_req_o,
  output logic [ADDR_W-1:0] nl_addr_o
);
  import vc_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
  logic [ENTRIES-1:0][LINE_W-1:0] data_q;
  logic [ENTRIES-1:0]             hit_vec;
  logic                           lookup_hit;
  logic [IDX_W-1:0]               hit_idx;
  logic [IDX_W-1:0]               victim_idx;

  vc_op_e           op;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_valid;

  vc_match #(.N(ENTRIES), .AW(ADDR_W), .IW(IDX_W)) u_match (
    .valid_i   (valid_q),
    .tag_i     (tag_q),
    .addr_i    (req_addr_i),
    .hit_vec_o (hit_vec),
    .hit_o     (lookup_hit),
    .hit_idx_o (hit_idx)
  );

  always_comb begin
    if (req_valid_i && lookup_hit)         op = VC_OP_SWAP;
    else if (req_valid_i && evict_valid_i) op = VC_OP_FILL;
    else                                   op = VC_OP_NONE;
  end

  assign wr_en    = (op != VC_OP_NONE);
  assign wr_idx   = (op == VC_OP_SWAP) ? hit_idx : victim_idx;
  // swap with no displaced line frees the slot
  assign wr_valid = (op == VC_OP_SWAP) ? evict_valid_i : 1'b1;

  vc_lru #(.N(ENTRIES), .IW(IDX_W)) u_lru (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .touch_i      (wr_en),
    .touch_idx_i  (wr_idx),
    .valid_i      (valid_q),
    .victim_idx_o (victim_idx)
  );

  vc_entry_array #(.N(ENTRIES), .AW(ADDR_W), .DW(LINE_W), .IW(IDX_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_valid_i (wr_valid),
    .wr_addr_i  (evict_addr_i),
    .wr_data_i  (evict_data_i),
    .valid_o    (valid_q),
    .tag_o      (tag_q),
    .data_o     (data_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_data_o  <= '0;
      nl_req_o     <= 1'b0;
      nl_addr_o    <= '0;
    end else begin
      resp_valid_o <= req_valid_i;
      resp_hit_o   <= req_valid_i && lookup_hit;
      resp_data_o  <= (req_valid_i && lookup_hit) ? data_q[hit_idx] : '0;
      nl_req_o     <= req_valid_i && !lookup_hit;
      if (req_valid_i && !lookup_hit) nl_addr_o <= req_addr_i;
    end
  end

  // R2
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  // R2
  hit_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && lookup_hit |=> resp_valid_o && resp_hit_o && !nl_req_o);

  // R3
  miss_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && !resp_hit_o |-> nl_req_o && nl_addr_o == $past(req_addr_i));

  // R4
  swap_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && lookup_hit && evict_valid_i |=>
      valid_q[$past(hit_idx)] && tag_q[$past(hit_idx)] == $past(evict_addr_i));

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !resp_valid_o && !nl_req_o && $stable(valid_q));
endmodule

// File: tb/victim_cache_tb.sv
`timescale 1ns/1ps
module victim_cache_tb;
  localparam int N  = 4;
  localparam int AW = 26;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          evict_valid = 1'b0;
  logic [AW-1:0] evict_addr = '0;
  logic [DW-1:0] evict_data = '0;
  logic          resp_valid, resp_hit, nl_req;
  logic [DW-1:0] resp_data;
  logic [AW-1:0] nl_addr;

  always #2.5 clk = ~clk;

  victim_cache #(.ENTRIES(N), .ADDR_W(AW), .LINE_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .evict_valid_i(evict_valid), .evict_addr_i(evict_addr), .evict_data_i(evict_data),
    .resp_valid_o(resp_valid), .resp_hit_o(resp_hit), .resp_data_o(resp_data),
    .nl_req_o(nl_req), .nl_addr_o(nl_addr)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model: slot contents plus recency queue, most recent first
  bit            m_valid [N];
  logic [AW-1:0] m_addr  [N];
  logic [DW-1:0] m_data  [N];
  int            order[$];

  logic          e_valid, e_hit, e_nl;
  logic [DW-1:0] e_data;
  logic [AW-1:0] e_nladdr;
  string         e_tag;
  string         cur_tag = "";

  task automatic model_reset();
    order.delete();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_addr[i] = '0; m_data[i] = '0;
      order.push_back(i);
    end
    e_valid = 0; e_hit = 0; e_nl = 0; e_data = '0; e_nladdr = '0; e_tag = "R1";
  endtask

  function automatic bool_held(logic [AW-1:0] a);
    bool_held = 0;
    for (int i = 0; i < N; i++) if (m_valid[i] && m_addr[i] == a) bool_held = 1;
  endfunction

  task automatic touch(int k);
    for (int i = 0; i < order.size(); i++) if (order[i] == k) begin order.delete(i); break; end
    order.push_front(k);
  endtask

  task automatic check();
    n_cmp++;
    if (resp_valid !== e_valid || resp_hit !== e_hit || resp_data !== e_data ||
        nl_req !== e_nl || (e_nl && nl_addr !== e_nladdr)) begin
      n_bad++;
      $display("FAIL %s: got v=%0b h=%0b d=%h nl=%0b a=%h exp v=%0b h=%0b d=%h nl=%0b a=%h",
               e_tag, resp_valid, resp_hit, resp_data, nl_req, nl_addr,
               e_valid, e_hit, e_data, e_nl, e_nladdr);
    end
  endtask

  task automatic step(bit rq, logic [AW-1:0] ra, bit ev, logic [AW-1:0] ea);
    int hi;
    int slot;
    logic [DW-1:0] ed;
    @(negedge clk);
    check();
    ed = {$urandom(), $urandom()};
    req_valid = rq; req_addr = ra; evict_valid = ev; evict_addr = ea; evict_data = ed;
    hi = -1;
    for (int i = 0; i < N; i++) if (m_valid[i] && m_addr[i] == ra) hi = i;
    e_valid  = rq;
    e_hit    = rq && hi >= 0;
    e_data   = (rq && hi >= 0) ? m_data[hi] : '0;
    e_nl     = rq && hi < 0;
    e_nladdr = ra;
    e_tag    = !rq ? "R8" : (hi >= 0 ? "R2" : "R3");
    if (cur_tag != "" && rq) e_tag = cur_tag;
    if (rq && hi >= 0) begin
      m_valid[hi] = ev; m_addr[hi] = ea; m_data[hi] = ed; touch(hi);
    end else if (rq && ev) begin
      slot = -1;
      for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) slot = i;
      if (slot < 0) slot = order[order.size() - 1];
      m_valid[slot] = 1; m_addr[slot] = ea; m_data[slot] = ed; touch(slot);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; req_valid = 0; evict_valid = 0;
    repeat (2) @(negedge clk);
    n_cmp++;
    if (resp_valid !== 1'b0 || nl_req !== 1'b0 || resp_hit !== 1'b0 || resp_data !== '0) begin
      n_bad++;
      $display("FAIL R1: in reset got v=%0b nl=%0b h=%0b d=%h exp 0", resp_valid, nl_req, resp_hit, resp_data);
    end
    rst_ni = 1;
    model_reset();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    // R1: empty after reset, first lookup misses
    cur_tag = "R1";
    step(0, 0, 0, 0);
    step(1, 26'h3, 0, 0);
    // R5: fill all slots through misses
    cur_tag = "R5";
    for (int i = 0; i < N; i++) step(1, 26'h40 + i, 1, 26'h100 + i);
    for (int i = 0; i < N; i++) step(1, 26'h60 + i, 1, 26'h300 + i); // full: LRU evicts the fills
    // R4: swap on hit, returned line gone, evicted line present
    cur_tag = "R4";
    step(1, 26'h300, 1, 26'h200);
    step(1, 26'h300, 0, 0);
    step(1, 26'h200, 1, 26'h201);
    step(1, 26'h201, 1, 26'h200);
    // R6: LRU replacement after touches
    do_reset();
    cur_tag = "R6";
    for (int i = 0; i < N; i++) step(1, 26'h50 + i, 1, 26'h110 + i);
    step(1, 26'h110, 1, 26'h120);
    step(1, 26'h70, 1, 26'h130);
    step(1, 26'h111, 0, 0);
    step(1, 26'h112, 0, 0);
    step(1, 26'h120, 0, 0);
    step(1, 26'h130, 0, 0);
    // R7: hit without displaced line frees its slot; miss without one stores nothing
    do_reset();
    cur_tag = "R7";
    for (int i = 0; i < N; i++) step(1, 26'h50 + i, 1, 26'h140 + i);
    step(1, 26'h142, 0, 0);
    step(1, 26'h142, 0, 0);
    step(1, 26'h77, 0, 0);
    step(1, 26'h78, 1, 26'h150);
    for (int i = 0; i < N; i++) step(1, 26'h140 + i, 0, 0);
    step(1, 26'h150, 0, 0);
    // R8: idle cycles with evict inputs toggling do nothing
    do_reset();
    step(1, 26'h9, 1, 26'h160);
    cur_tag = "R8";
    step(0, 26'h160, 1, 26'h170);
    step(0, 26'h160, 1, 26'h171);
    step(1, 26'h170, 0, 0);
    step(1, 26'h160, 0, 0);
    // mixed traffic over a small pool
    cur_tag = "";
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] ra, ea;
      bit ev;
      bit rq;
      rq = ($urandom_range(0, 7) != 0);
      ra = 26'h10 + $urandom_range(0, 11);
      ev = ($urandom_range(0, 3) != 0);
      ea = 0;
      if (ev) begin
        ev = 0;
        for (int t = 0; t < 20; t++) begin
          logic [AW-1:0] c;
          c = 26'h10 + $urandom_range(0, 11);
          if (c != ra && !bool_held(c)) begin ea = c; ev = 1; break; end
        end
      end
      step(rq, ra, ev, ea);
    end
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule